// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose I/O pins, 32 by default. Each pin has its own input, output value and output enable, plus pad controls for pull resistors and a 3-bit drive-strength code. Each pin's input passes through a multi-flop synchroniser before any logic uses it. A detector per pin then turns level or edge activity into a sticky status bit. All control and status is reached through a simple word-wide register port. Writes take effect on the clock edge. Reads return combinationally for the address presented.

Each pin takes one of five trigger behaviours from three independent configuration bits: level/edge select, dual-edge and polarity. These give rising edge, falling edge, both edges, high level or low level. Software can read both the raw latched status and the status gated by a per-pin enable. It acknowledges events by writing ones to a dedicated clear address. One interrupt line, the OR of all enabled status bits, goes to the host.

Register map (byte offsets, word aligned):
- 0x00 synchronised pin level (read-only)
- 0x04 output value
- 0x08 output enable
- 0x10 interrupt enable
- 0x14 level select
- 0x18 polarity
- 0x1C dual-edge
- 0x20 raw status (read-only)
- 0x24 enabled status (read-only)
- 0x28 acknowledge (write-one-to-clear, reads 0)
- 0x30 pull enable
- 0x34 pull direction
- 0x40, 0x44, 0x48 drive-strength code bits 0, 1 and 2

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, every pad output (value, enable, pull enable, pull direction, drive code) is zero and `irq_o` is low.
- R2: Address 0x00 returns the pin inputs after two register stages: a level applied between clock edges is not yet visible after one rising edge and is visible after the second, whatever the output enable holds.
- R3: `pad_out_o` and `pad_oe_o` follow the registers at 0x04 and 0x08 bit for bit, and both registers read back what was written.
- R4: With level select 0 and dual-edge 0, a pin with polarity 1 latches raw status (0x20) on a rising edge only, and a pin with polarity 0 latches it on a falling edge only.
- R5: With dual-edge 1 and level select 0, a pin latches status on both rising and falling edges whatever its polarity bit holds.
- R6: With level select 1, status latches on every cycle the pin sits at the active level (1 when polarity is 1, 0 when polarity is 0), so an acknowledge while the level persists leaves the bit set; once the level is gone an acknowledge clears it.
- R7: Address 0x24 reads raw status AND interrupt enable, and `irq_o` is high exactly when that value is non-zero; a disabled pin still latches raw status but does not raise `irq_o`.
- R8: Writing 1 to a bit of 0x28 clears that raw status bit, writing 0 leaves it unchanged, 0x28 reads as zero, and writes to 0x00, 0x20 and 0x24 change nothing.
- R9: When a detected event and an acknowledge of the same pin fall in the same clock cycle, the event wins and the status bit stays set.
- R10: `pull_en_o` and `pull_up_o` follow the registers at 0x30 and 0x34 (pull direction 1 means pull-up, 0 means pull-down).
- R11: `drv_str_o[3*i+2:3*i]` carries pin i's drive code, whose bits 0, 1 and 2 come from bit i of 0x40, 0x44 and 0x48; code c stands for 2*(c+1) mA.
- R12: Reads of addresses outside the map return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W (8) | Byte address within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pad_in_i | input | NUM_PINS (32) | Asynchronous pin levels |
| pad_out_o | output | NUM_PINS (32) | Output value per pin |
| pad_oe_o | output | NUM_PINS (32) | Output enable per pin |
| pull_en_o | output | NUM_PINS (32) | Pull resistor active per pin |
| pull_up_o | output | NUM_PINS (32) | Pull direction per pin, 1 = up |
| drv_str_o | output | 3*NUM_PINS (96) | Packed 3-bit drive code per pin |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The two functions that can land in the same cycle are event latching and the acknowledge write. For an edge-mode pin, the bench places the acknowledge write on the exact rising edge where the detector's synchronised-edge pulse is latched. It then judges that the raw bit stays set. As a control, it repeats the pattern with the acknowledge one edge later and expects the bit to clear. A level-mode pin acknowledged while its level is still active gives the same collision on every cycle. The bench checks that the bit reads set right after the write, and clears only after the level is removed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int DATA_W  = 32;
   localparam int DRV_BITS = 3;
   localparam int OFF_W   = 8;

   localparam logic [OFF_W-1:0] OFF_PIN_IN   = 8'h00;
   localparam logic [OFF_W-1:0] OFF_OUT_VAL  = 8'h04;
   localparam logic [OFF_W-1:0] OFF_OUT_EN   = 8'h08;
   localparam logic [OFF_W-1:0] OFF_IRQ_EN   = 8'h10;
   localparam logic [OFF_W-1:0] OFF_LVL_SEL  = 8'h14;
   localparam logic [OFF_W-1:0] OFF_POL      = 8'h18;
   localparam logic [OFF_W-1:0] OFF_DUAL     = 8'h1C;
   localparam logic [OFF_W-1:0] OFF_RAW      = 8'h20;
   localparam logic [OFF_W-1:0] OFF_PEND     = 8'h24;
   localparam logic [OFF_W-1:0] OFF_ACK      = 8'h28;
   localparam logic [OFF_W-1:0] OFF_PULL_EN  = 8'h30;
   localparam logic [OFF_W-1:0] OFF_PULL_UP  = 8'h34;
   localparam logic [OFF_W-1:0] OFF_DRV_BASE = 8'h40;
   localparam logic [OFF_W-1:0] OFF_DRV_STEP = 8'h04;

   typedef enum logic [1:0] {
      TRIG_EDGE_ONE = 2'b00,
      TRIG_EDGE_TWO = 2'b01,
      TRIG_LEVEL    = 2'b10
   } trig_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 32,
   parameter int STAGES   = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] async_i,
   output logic [NUM_PINS-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NUM_PINS-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] lvl_sel_i,
   input  logic [NUM_PINS-1:0] pol_i,
   input  logic [NUM_PINS-1:0] dual_i,
   output logic [NUM_PINS-1:0] event_o
);
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= level_i;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic       rise, fall, active;
      trig_kind_e kind;

      assign rise   = level_i[p] & ~prev_q[p];
      assign fall   = ~level_i[p] & prev_q[p];
      assign active = pol_i[p] ? level_i[p] : ~level_i[p];
      assign kind   = lvl_sel_i[p] ? TRIG_LEVEL
                    : (dual_i[p] ? TRIG_EDGE_TWO : TRIG_EDGE_ONE);

      always_comb begin
         unique case (kind)
            TRIG_LEVEL:    event_o[p] = active;
            TRIG_EDGE_TWO: event_o[p] = rise | fall;
            default:       event_o[p] = pol_i[p] ? rise : fall;
         endcase
      end
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic [DATA_W-1:0]                 rdata_o,
   input  logic [NUM_PINS-1:0]               pin_level_i,
   input  logic [NUM_PINS-1:0]               event_i,
   output logic [NUM_PINS-1:0]               out_val_o,
   output logic [NUM_PINS-1:0]               out_en_o,
   output logic [NUM_PINS-1:0]               irq_en_o,
   output logic [NUM_PINS-1:0]               lvl_sel_o,
   output logic [NUM_PINS-1:0]               pol_o,
   output logic [NUM_PINS-1:0]               dual_o,
   output logic [NUM_PINS-1:0]               pull_en_o,
   output logic [NUM_PINS-1:0]               pull_up_o,
   output logic [DRV_BITS-1:0][NUM_PINS-1:0] drv_plane_o,
   output logic [NUM_PINS-1:0]               raw_sts_o
);
   localparam int NCFG = 8;

   logic [NUM_PINS-1:0]               wpins;
   logic [NCFG-1:0][NUM_PINS-1:0]     cfg_q;
   logic [NCFG-1:0][ADDR_W-1:0]       cfg_addr;
   logic [DRV_BITS-1:0][NUM_PINS-1:0] drv_q;
   logic [NUM_PINS-1:0]               sts_q;
   logic                              ack_hit;

   assign wpins = wdata_i[NUM_PINS-1:0];

   assign cfg_addr[0] = ADDR_W'(OFF_OUT_VAL);
   assign cfg_addr[1] = ADDR_W'(OFF_OUT_EN);
   assign cfg_addr[2] = ADDR_W'(OFF_IRQ_EN);
   assign cfg_addr[3] = ADDR_W'(OFF_LVL_SEL);
   assign cfg_addr[4] = ADDR_W'(OFF_POL);
   assign cfg_addr[5] = ADDR_W'(OFF_DUAL);
   assign cfg_addr[6] = ADDR_W'(OFF_PULL_EN);
   assign cfg_addr[7] = ADDR_W'(OFF_PULL_UP);

   for (genvar r = 0; r < NCFG; r++) begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                            cfg_q[r] <= '0;
         else if (wr_i && addr_i == cfg_addr[r]) cfg_q[r] <= wpins;
      end
   end

   for (genvar k = 0; k < DRV_BITS; k++) begin : g_drv
      localparam logic [ADDR_W-1:0] PLANE_ADDR =
         ADDR_W'(OFF_DRV_BASE) + ADDR_W'(k) * ADDR_W'(OFF_DRV_STEP);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          drv_q[k] <= '0;
         else if (wr_i && addr_i == PLANE_ADDR) drv_q[k] <= wpins;
      end
   end

   // Sticky status: a fresh event takes priority over a same-cycle acknowledge.
   assign ack_hit = wr_i && (addr_i == ADDR_W'(OFF_ACK));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q <= '0;
      else         sts_q <= (sts_q & ~(ack_hit ? wpins : '0)) | event_i;
   end

   always_comb begin
      rdata_o = '0;
      for (int r = 0; r < NCFG; r++) begin
         if (addr_i == cfg_addr[r]) rdata_o = DATA_W'(cfg_q[r]);
      end
      for (int k = 0; k < DRV_BITS; k++) begin
         if (addr_i == ADDR_W'(OFF_DRV_BASE) + ADDR_W'(k) * ADDR_W'(OFF_DRV_STEP))
            rdata_o = DATA_W'(drv_q[k]);
      end
      if (addr_i == ADDR_W'(OFF_PIN_IN)) rdata_o = DATA_W'(pin_level_i);
      if (addr_i == ADDR_W'(OFF_RAW))    rdata_o = DATA_W'(sts_q);
      if (addr_i == ADDR_W'(OFF_PEND))   rdata_o = DATA_W'(sts_q & cfg_q[2]);
   end

   assign out_val_o   = cfg_q[0];
   assign out_en_o    = cfg_q[1];
   assign irq_en_o    = cfg_q[2];
   assign lvl_sel_o   = cfg_q[3];
   assign pol_o       = cfg_q[4];
   assign dual_o      = cfg_q[5];
   assign pull_en_o   = cfg_q[6];
   assign pull_up_o   = cfg_q[7];
   assign drv_plane_o = drv_q;
   assign raw_sts_o   = sts_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         bus_wr_i,
   input  logic [ADDR_W-1:0]            bus_addr_i,
   input  logic [31:0]                  bus_wdata_i,
   output logic [31:0]                  bus_rdata_o,
   input  logic [NUM_PINS-1:0]          pad_in_i,
   output logic [NUM_PINS-1:0]          pad_out_o,
   output logic [NUM_PINS-1:0]          pad_oe_o,
   output logic [NUM_PINS-1:0]          pull_en_o,
   output logic [NUM_PINS-1:0]          pull_up_o,
   output logic [3*NUM_PINS-1:0]        drv_str_o,
   output logic                         irq_o
);
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_irq_bank: NUM_PINS must lie in 1..32");
   end
   if (ADDR_W < 7 || ADDR_W > OFF_W) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must lie in 7..8");
   end

   logic [NUM_PINS-1:0]               pin_level;
   logic [NUM_PINS-1:0]               evt;
   logic [NUM_PINS-1:0]               lvl_sel, pol, dual, irq_en, raw_sts;
   logic [DRV_BITS-1:0][NUM_PINS-1:0] drv_plane;

   gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pad_in_i),
      .sync_o  (pin_level)
   );

   gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .level_i   (pin_level),
      .lvl_sel_i (lvl_sel),
      .pol_i     (pol),
      .dual_i    (dual),
      .event_o   (evt)
   );

   gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (bus_wr_i),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .rdata_o     (bus_rdata_o),
      .pin_level_i (pin_level),
      .event_i     (evt),
      .out_val_o   (pad_out_o),
      .out_en_o    (pad_oe_o),
      .irq_en_o    (irq_en),
      .lvl_sel_o   (lvl_sel),
      .pol_o       (pol),
      .dual_o      (dual),
      .pull_en_o   (pull_en_o),
      .pull_up_o   (pull_up_o),
      .drv_plane_o (drv_plane),
      .raw_sts_o   (raw_sts)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_drv_pin
      for (genvar b = 0; b < DRV_BITS; b++) begin : g_bit
         assign drv_str_o[p*DRV_BITS + b] = drv_plane[b][p];
      end
   end

   assign irq_o = |(raw_sts & irq_en);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                bus_wr_i,
   input logic [ADDR_W-1:0]   bus_addr_i,
   input logic [31:0]         bus_wdata_i,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] pad_oe_o,
   input logic [NUM_PINS-1:0] raw_sts,
   input logic [NUM_PINS-1:0] evt,
   input logic [NUM_PINS-1:0] irq_en
);
   logic [NUM_PINS-1:0] ack_mask;
   assign ack_mask = (bus_wr_i && bus_addr_i == ADDR_W'(OFF_ACK))
                   ? bus_wdata_i[NUM_PINS-1:0] : '0;

   // R4
   evt_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt != '0) |=> ((raw_sts & $past(evt)) == $past(evt)));

   // R8
   sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(raw_sts & ~ack_mask) & ~raw_sts) == '0));

   // R8
   ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((raw_sts & $past(ack_mask & ~evt)) == '0));

   // R7
   irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((raw_sts & irq_en) != '0));

   // R7
   irq_off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_en == '0) |-> !irq_o);

   // R3
   oe_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_wr_i && bus_addr_i == ADDR_W'(OFF_OUT_EN)) |=> $stable(pad_oe_o));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .pad_oe_o    (pad_oe_o),
   .raw_sts     (raw_sts),
   .evt         (evt),
   .irq_en      (irq_en)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 32;

   localparam logic [7:0] A_PIN  = 8'h00, A_OVAL = 8'h04, A_OEN = 8'h08,
                          A_IEN  = 8'h10, A_LVL  = 8'h14, A_POL = 8'h18,
                          A_DUAL = 8'h1C, A_RAW  = 8'h20, A_PEND = 8'h24,
                          A_ACK  = 8'h28, A_PEN  = 8'h30, A_PUP = 8'h34,
                          A_D0   = 8'h40, A_D1   = 8'h44, A_D2  = 8'h48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pins = '0;
   logic [N-1:0]  pad_out, pad_oe, pull_en, pull_up;
   logic [3*N-1:0] drv_str;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_bank uut (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pad_in_i(pins),
      .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pull_en_o(pull_en),
      .pull_up_o(pull_up), .drv_str_o(drv_str), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic cleanup();
      wr(A_LVL, '0); wr(A_POL, '0); wr(A_DUAL, '0); wr(A_IEN, '0);
      @(negedge clk); pins = '0;
      settle();
      wr(A_ACK, '1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_RAW, v);  check("R1 raw", v, 0);
      rd(A_OEN, v);  check("R1 oe reg", v, 0);
      rd(A_D2, v);   check("R1 drv plane", v, 0);
      check("R1 pads", {pad_out | pad_oe | pull_en | pull_up}, 0);
      check("R1 drv", 32'(|drv_str), 0);
      check("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_pin_in();
      logic [31:0] v;
      wr(A_OEN, 32'h0000_FFFF);
      @(negedge clk); pins = 32'h1234_5678;
      @(negedge clk); rd(A_PIN, v); check("R2 one edge", v, 0);
      @(negedge clk); rd(A_PIN, v); check("R2 two edges", v, 32'h1234_5678);
      wr(A_OEN, 0);
      cleanup();
   endtask

   task automatic t_outputs();
      logic [31:0] v;
      wr(A_OVAL, 32'hA5A5_0F0F); wr(A_OEN, 32'h00FF_FF00);
      check("R3 pad_out", pad_out, 32'hA5A5_0F0F);
      check("R3 pad_oe", pad_oe, 32'h00FF_FF00);
      rd(A_OVAL, v); check("R3 readback", v, 32'hA5A5_0F0F);
      wr(A_OVAL, 0); wr(A_OEN, 0);
   endtask

   task automatic t_edges();
      logic [31:0] v;
      wr(A_POL, 32'h10);              // pin4 rising, pin3 falling
      @(negedge clk); pins[3] = 1'b1; pins[4] = 1'b1;
      settle(); rd(A_RAW, v); check("R4 rise", v, 32'h10);
      wr(A_ACK, '1);
      @(negedge clk); pins[3] = 1'b0; pins[4] = 1'b0;
      settle(); rd(A_RAW, v); check("R4 fall", v, 32'h08);
      cleanup();
   endtask

   task automatic t_dual();
      logic [31:0] v;
      wr(A_DUAL, 32'h20);
      @(negedge clk); pins[5] = 1'b1;
      settle(); rd(A_RAW, v); check("R5 rise", v, 32'h20);
      wr(A_ACK, 32'h20); wr(A_POL, 32'h20);
      @(negedge clk); pins[5] = 1'b0;
      settle(); rd(A_RAW, v); check("R5 fall pol1", v, 32'h20);
      cleanup();
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(A_POL, 32'h4); wr(A_LVL, 32'h4);
      @(negedge clk); pins[2] = 1'b1;
      settle(); rd(A_RAW, v); check("R6 high", v, 32'h4);
      wr(A_ACK, 32'h4); rd(A_RAW, v); check("R6 ack while high", v, 32'h4);
      @(negedge clk); pins[2] = 1'b0;
      settle(); wr(A_ACK, 32'h4); rd(A_RAW, v); check("R6 ack after", v, 0);
      cleanup();
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr(A_POL, 32'h80);
      @(negedge clk); pins[7] = 1'b1;
      settle();
      rd(A_RAW, v);  check("R7 raw latched", v, 32'h80);
      rd(A_PEND, v); check("R7 pend masked", v, 0);
      check("R7 irq masked", 32'(irq), 0);
      wr(A_IEN, 32'h81);
      rd(A_PEND, v); check("R7 pend", v, 32'h80);
      check("R7 irq", 32'(irq), 1);
      wr(A_ACK, 32'h80); check("R7 irq cleared", 32'(irq), 0);
      cleanup();
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(A_POL, 32'h300);
      @(negedge clk); pins[8] = 1'b1; pins[9] = 1'b1;
      settle();
      wr(A_ACK, 32'h100); rd(A_RAW, v); check("R8 one cleared", v, 32'h200);
      wr(A_ACK, 0);       rd(A_RAW, v); check("R8 zero write", v, 32'h200);
      wr(A_RAW, 0); wr(A_PEND, 0); wr(A_PIN, '1);
      rd(A_RAW, v); check("R8 read-only", v, 32'h200);
      rd(A_ACK, v); check("R8 ack reads 0", v, 0);
      cleanup();
   endtask

   task automatic t_collide();
      logic [31:0] v;
      wr(A_DUAL, 32'h20);
      @(negedge clk); pins[5] = 1'b1;
      settle();
      @(negedge clk); pins[5] = 1'b0;
      @(negedge clk);
      wr(A_ACK, 32'h20);                     // lands on the latch edge
      rd(A_RAW, v); check("R9 event wins", v, 32'h20);
      @(negedge clk); pins[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(A_ACK, 32'h20);                     // one edge after the latch
      rd(A_RAW, v); check("R9 control", v, 0);
      cleanup();
   endtask

   task automatic t_pads();
      logic [31:0] v;
      wr(A_PEN, 32'hF0F0_0001); wr(A_PUP, 32'h3000_0001);
      check("R10 pull_en", pull_en, 32'hF0F0_0001);
      check("R10 pull_up", pull_up, 32'h3000_0001);
      wr(A_D0, 32'h8000_0001); wr(A_D1, 32'h0000_0003); wr(A_D2, 32'h8000_0001);
      check("R11 pin0", 32'(drv_str[2:0]), 7);
      check("R11 pin1", 32'(drv_str[5:3]), 2);
      check("R11 pin31", 32'(drv_str[95:93]), 5);
      check("R11 pin2", 32'(drv_str[8:6]), 0);
      rd(A_D1, v); check("R11 readback", v, 32'h3);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'h0C, v); check("R12 hole", v, 0);
      rd(8'hFC, v); check("R12 top", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_pin_in();
      t_outputs();
      t_edges();
      t_dual();
      t_level();
      t_mask();
      t_clear();
      t_collide();
      t_pads();
      t_unmapped();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end
endmodule